// File: doc/BRIEF.md
# Calendar Time Counter With Alarm Match

This block keeps wall-clock time from seconds up to a two-digit year, stepped by a one-per-second strobe. Time is held internally in plain binary. It is shown on seven byte-wide outputs: seconds, minutes, hours, weekday, day of month, month and year. Control inputs choose the shown encoding (packed decimal or binary) and the hour style (24-hour, or 12-hour with a PM flag).

Each accepted strobe advances the counter at once and starts an update window of `UPD_DELAY` clock cycles. During the window the update flag is high, unless the freeze input holds the display. When the window ends, four things happen in the same cycle: the display bytes are refreshed (unless frozen), the update flag drops, an update-done pulse is issued, and the time is compared against three alarm bytes. A parallel load port sets both the counter and the display from bytes written in the current encoding.

Top module: `cal_counter`

## Requirements
- R1: With `bin_mode`=1 each time byte is the plain binary value. With `bin_mode`=0 it is packed decimal: tens digit in bits 7:4, units digit in bits 3:0.
- R2: With `mode_24h`=1 the hour byte carries 0–23. With `mode_24h`=0 it carries the hour mod 12, and bit 7 is set when the hour is 12 or more.
- R3: Seconds and minutes roll from 59 to 0 and hours from 23 to 0. The weekday counts 0–6 and goes from 6 to 0 when the day changes.
- R4: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. After the last day the day becomes 1 and the month advances; month 12 goes to 1, and the year advances.
- R5: The year shows 0–99 and rolls from 99 to 0. February has 29 days when the full year 2000+year is a leap year (divisible by 4, and either not by 100 or by 400).
- R6: A strobe advances time only when `osc_sel` equals 3'b010. Under any other value the strobe is ignored: no update window, and no change of time.
- R7: A strobe accepted at edge E sets `uip` after E, unless frozen. `uip` stays high through edge E+`UPD_DELAY`-1. At edge E+`UPD_DELAY` the display refreshes, `uip` clears and `upd_pulse` is high for one cycle.
- R8: While `freeze`=1, `uip` is not raised and the display bytes do not change at the end of the window. The counter still advances, so the time shown once `freeze` drops includes those seconds.
- R9: At the end of each window `alarm_pulse` is high for one cycle when all three alarm bytes match. A byte matches if its bits 7:6 are 2'b11, or if it equals the seconds, minutes or hours value in the current encoding.
- R10: `ld_en`=1 writes the seven load bytes into the display directly and, decoded under the current mode, into the counter. A strobe in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle strobe per second |
| osc_sel | input | 3 | Counting enabled when 3'b010 |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed decimal |
| mode_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| freeze | input | 1 | Holds the display and suppresses `uip` |
| ld_en | input | 1 | Load the time bytes below |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_wday | input | 8 | Weekday to load (0–6) |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load (1–12) |
| ld_year | input | 8 | Year to load (0–99) |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| reg_sec | output | 8 | Shown seconds |
| reg_min | output | 8 | Shown minutes |
| reg_hour | output | 8 | Shown hours |
| reg_wday | output | 8 | Shown weekday |
| reg_mday | output | 8 | Shown day of month |
| reg_mon | output | 8 | Shown month |
| reg_year | output | 8 | Shown year |
| uip | output | 1 | Update window in progress |
| upd_pulse | output | 1 | One-cycle pulse at end of window |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
The bench aims at the full carry chain from 23:59:59 on 31 December 99. A design with a wrong compare limit would stop one step early or late, or leave the year at 100. It runs February 28 in years 00, 04 and 01, plus a 30-day month: an incomplete leap rule makes year 00 skip the 29th, or makes 01 show it. The 12-hour cases at 11 AM, 1 PM and 11 PM expose a missing or misplaced PM flag, and a noon shown as 12 instead of 0 with bit 7. Other cases cover a strobe under a stopped oscillator code, the held display under freeze, and alarm bytes given in the wrong encoding: a design that ignores the gate, refreshes a frozen display, or compares raw binary would show the wrong second or fire a false alarm.

// File: rtl/cal_counter.sv
module cal_counter #(
  parameter int UPD_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_sel,
  input  logic       bin_mode,
  input  logic       mode_24h,
  input  logic       freeze,
  input  logic       ld_en,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  output logic [7:0] reg_sec,
  output logic [7:0] reg_min,
  output logic [7:0] reg_hour,
  output logic [7:0] reg_wday,
  output logic [7:0] reg_mday,
  output logic [7:0] reg_mon,
  output logic [7:0] reg_year,
  output logic       uip,
  output logic       upd_pulse,
  output logic       alarm_pulse
);
  localparam int DW = $clog2(UPD_DELAY + 1);

  logic [5:0] c_sec, c_min, n_sec, n_min;
  logic [4:0] c_hr, n_hr, c_md, n_md;
  logic [2:0] c_wd, n_wd;
  logic [3:0] c_mo, n_mo;
  logic [6:0] c_yr, n_yr;
  logic       busy;
  logic [DW-1:0] dly;
  logic [7:0] e_sec, e_min, e_hr, e_wd, e_md, e_mo, e_yr;
  logic [4:0] mdays;
  logic [6:0] ld_hr_bin;
  logic       tick_ok, alarm_hit;

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return bin ? {1'b0, v} : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [4:0] days_in(input logic [3:0] mo, input logic [6:0] yr);
    logic [11:0] full;
    logic        leap;
    full = 12'd2000 + 12'(yr);
    leap = (full % 12'd4 == 0) && ((full % 12'd100 != 0) || (full % 12'd400 == 0));
    case (mo)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic match(input logic [7:0] a, input logic [7:0] cur);
    return (a[7:6] == 2'b11) || (a == cur);
  endfunction

  assign mdays   = days_in(c_mo, c_yr);
  assign tick_ok = sec_tick && (osc_sel == 3'b010) && !busy && !ld_en;

  assign e_sec = enc(7'(c_sec), bin_mode);
  assign e_min = enc(7'(c_min), bin_mode);
  assign e_wd  = enc(7'(c_wd), bin_mode);
  assign e_md  = enc(7'(c_md), bin_mode);
  assign e_mo  = enc(7'(c_mo), bin_mode);
  assign e_yr  = enc(c_yr, bin_mode);

  always_comb begin
    logic [6:0] h12;
    h12 = 7'(c_hr) % 7'd12;
    if (mode_24h) e_hr = enc(7'(c_hr), bin_mode);
    else          e_hr = enc(h12, bin_mode) | ((c_hr >= 5'd12) ? 8'h80 : 8'h00);
  end

  always_comb begin
    ld_hr_bin = dec({1'b0, ld_hour[6:0]}, bin_mode);
    if (!mode_24h && ld_hour[7]) ld_hr_bin = ld_hr_bin + 7'd12;
  end

  assign alarm_hit = match(alm_sec, e_sec) && match(alm_min, e_min) && match(alm_hour, e_hr);

  always_comb begin
    n_sec = c_sec + 6'd1;
    n_min = c_min;
    n_hr  = c_hr;
    n_wd  = c_wd;
    n_md  = c_md;
    n_mo  = c_mo;
    n_yr  = c_yr;
    if (c_sec >= 6'd59) begin
      n_sec = '0;
      n_min = c_min + 6'd1;
      if (c_min >= 6'd59) begin
        n_min = '0;
        n_hr  = c_hr + 5'd1;
        if (c_hr >= 5'd23) begin
          n_hr = '0;
          n_wd = (c_wd >= 3'd6) ? 3'd0 : c_wd + 3'd1;
          if (c_md >= mdays) begin
            n_md = 5'd1;
            if (c_mo >= 4'd12) begin
              n_mo = 4'd1;
              n_yr = (c_yr >= 7'd99) ? 7'd0 : c_yr + 7'd1;
            end else begin
              n_mo = c_mo + 4'd1;
            end
          end else begin
            n_md = c_md + 5'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sec <= '0; c_min <= '0; c_hr <= '0; c_wd <= '0;
      c_md <= 5'd1; c_mo <= 4'd1; c_yr <= '0;
      reg_sec <= '0; reg_min <= '0; reg_hour <= '0; reg_wday <= '0;
      reg_mday <= 8'h01; reg_mon <= 8'h01; reg_year <= '0;
      busy <= 1'b0; dly <= '0; uip <= 1'b0;
      upd_pulse <= 1'b0; alarm_pulse <= 1'b0;
    end else begin
      upd_pulse   <= 1'b0;
      alarm_pulse <= 1'b0;
      if (ld_en) begin
        c_sec <= 6'(dec(ld_sec, bin_mode));
        c_min <= 6'(dec(ld_min, bin_mode));
        c_hr  <= 5'(ld_hr_bin);
        c_wd  <= 3'(dec(ld_wday, bin_mode));
        c_md  <= 5'(dec(ld_mday, bin_mode));
        c_mo  <= 4'(dec(ld_mon, bin_mode));
        c_yr  <= dec(ld_year, bin_mode);
        reg_sec <= ld_sec; reg_min <= ld_min; reg_hour <= ld_hour;
        reg_wday <= ld_wday; reg_mday <= ld_mday; reg_mon <= ld_mon;
        reg_year <= ld_year;
      end else if (tick_ok) begin
        c_sec <= n_sec; c_min <= n_min; c_hr <= n_hr; c_wd <= n_wd;
        c_md <= n_md; c_mo <= n_mo; c_yr <= n_yr;
        busy <= 1'b1;
        dly  <= DW'(UPD_DELAY);
        uip  <= !freeze;
      end else if (busy) begin
        if (dly == DW'(1)) begin
          busy <= 1'b0;
          uip  <= 1'b0;
          upd_pulse   <= 1'b1;
          alarm_pulse <= alarm_hit;
          if (!freeze) begin
            reg_sec <= e_sec; reg_min <= e_min; reg_hour <= e_hr;
            reg_wday <= e_wd; reg_mday <= e_md; reg_mon <= e_mo;
            reg_year <= e_yr;
          end
        end else begin
          dly <= dly - DW'(1);
        end
      end
    end
  end

  p_osc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_sel != 3'b010 && !ld_en) |=> $stable(c_sec));

  p_uip_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && osc_sel == 3'b010 && !busy && !ld_en && !freeze) |=> uip);

  p_uip_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> !uip);

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && !$past(ld_en)) |-> $stable(reg_sec));

  p_freeze_nouip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !uip) |=> !uip);

  p_alarm_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> !alarm_pulse);
endmodule

// File: tb/test_cal_counter.sv
module test_cal_counter;
  localparam int CLK_P = 10;
  localparam int DLY   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_tick = 1'b0, bin_mode = 1'b0, mode_24h = 1'b1, freeze = 1'b0, ld_en = 1'b0;
  logic [2:0] osc_sel = 3'b010;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_wday = '0;
  logic [7:0] ld_mday = '0, ld_mon = '0, ld_year = '0;
  logic [7:0] alm_sec = 8'h3F, alm_min = 8'h3F, alm_hour = 8'h3F;
  logic [7:0] reg_sec, reg_min, reg_hour, reg_wday, reg_mday, reg_mon, reg_year;
  logic uip, upd_pulse, alarm_pulse;

  int checks = 0, errors = 0;
  logic t_uip_early, t_uip_late, t_upd, t_alm, t_uip_end;

  always #(CLK_P/2) clk = ~clk;

  cal_counter #(.UPD_DELAY(DLY)) i_cal_counter (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_sel(osc_sel),
    .bin_mode(bin_mode), .mode_24h(mode_24h), .freeze(freeze), .ld_en(ld_en),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
    .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .reg_sec(reg_sec), .reg_min(reg_min), .reg_hour(reg_hour), .reg_wday(reg_wday),
    .reg_mday(reg_mday), .reg_mon(reg_mon), .reg_year(reg_year),
    .uip(uip), .upd_pulse(upd_pulse), .alarm_pulse(alarm_pulse));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] h, m, s, wd, md, mo, yr);
    @(negedge clk);
    ld_hour = h; ld_min = m; ld_sec = s; ld_wday = wd;
    ld_mday = md; ld_mon = mo; ld_year = yr; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    t_uip_early = uip;
    repeat (DLY - 1) @(negedge clk);
    t_uip_late = uip;
    @(negedge clk);
    t_upd = upd_pulse; t_alm = alarm_pulse; t_uip_end = uip;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 reset uip", {7'b0, uip}, 8'h00);
    check("R3 reset sec", reg_sec, 8'h00);
    check("R4 reset mday", reg_mday, 8'h01);
    check("R4 reset mon", reg_mon, 8'h01);
  endtask

  task automatic t_full_rollover();
    bin_mode = 1'b0; mode_24h = 1'b1;
    do_load(8'h23, 8'h59, 8'h58, 8'h06, 8'h31, 8'h12, 8'h99);
    check("R10 load sec", reg_sec, 8'h58);
    do_tick();
    check("R1 bcd sec 59", reg_sec, 8'h59);
    do_tick();
    check("R3 sec wrap", reg_sec, 8'h00);
    check("R3 min wrap", reg_min, 8'h00);
    check("R3 hour wrap", reg_hour, 8'h00);
    check("R3 wday wrap", reg_wday, 8'h00);
    check("R4 mday wrap", reg_mday, 8'h01);
    check("R4 mon wrap", reg_mon, 8'h01);
    check("R5 year wrap", reg_year, 8'h00);
  endtask

  task automatic t_binary();
    bin_mode = 1'b1; mode_24h = 1'b1;
    do_load(8'd13, 8'd45, 8'd30, 8'd2, 8'd15, 8'd6, 8'd21);
    do_tick();
    check("R1 binary sec", reg_sec, 8'd31);
    check("R1 binary hour", reg_hour, 8'd13);
    check("R1 binary year", reg_year, 8'd21);
    bin_mode = 1'b0;
  endtask

  task automatic t_12h();
    bin_mode = 1'b0; mode_24h = 1'b0;
    do_load(8'h81, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h10);
    do_tick();
    check("R2 pm hour 2", reg_hour, 8'h82);
    check("R2 min after", reg_min, 8'h00);
    do_load(8'h11, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h10);
    do_tick();
    check("R2 noon", reg_hour, 8'h80);
    do_load(8'h91, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h10);
    do_tick();
    check("R2 midnight", reg_hour, 8'h00);
    check("R2 day step", reg_mday, 8'h11);
    mode_24h = 1'b1;
  endtask

  task automatic t_leap();
    bin_mode = 1'b0; mode_24h = 1'b1;
    do_load(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h04);
    do_tick();
    check("R5 leap 04 mday", reg_mday, 8'h29);
    check("R5 leap 04 mon", reg_mon, 8'h02);
    do_load(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h00);
    do_tick();
    check("R5 leap 00 mday", reg_mday, 8'h29);
    do_load(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h01);
    do_tick();
    check("R5 nonleap mday", reg_mday, 8'h01);
    check("R5 nonleap mon", reg_mon, 8'h03);
    do_load(8'h23, 8'h59, 8'h59, 8'h00, 8'h30, 8'h04, 8'h01);
    do_tick();
    check("R4 april end mday", reg_mday, 8'h01);
    check("R4 april end mon", reg_mon, 8'h05);
  endtask

  task automatic t_osc_gate();
    do_load(8'h05, 8'h05, 8'h10, 8'h00, 8'h01, 8'h01, 8'h01);
    osc_sel = 3'b000;
    do_tick();
    check("R6 no window uip", {7'b0, t_uip_early}, 8'h00);
    check("R6 no upd pulse", {7'b0, t_upd}, 8'h00);
    check("R6 sec held", reg_sec, 8'h10);
    osc_sel = 3'b010;
    do_tick();
    check("R6 single step", reg_sec, 8'h11);
  endtask

  task automatic t_window();
    do_load(8'h05, 8'h05, 8'h20, 8'h00, 8'h01, 8'h01, 8'h01);
    do_tick();
    check("R7 uip early", {7'b0, t_uip_early}, 8'h01);
    check("R7 uip late", {7'b0, t_uip_late}, 8'h01);
    check("R7 upd pulse", {7'b0, t_upd}, 8'h01);
    check("R7 uip end", {7'b0, t_uip_end}, 8'h00);
    check("R7 pulse gone", {7'b0, upd_pulse}, 8'h00);
  endtask

  task automatic t_freeze();
    do_load(8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    freeze = 1'b1;
    do_tick();
    check("R8 no uip", {7'b0, t_uip_early}, 8'h00);
    check("R8 upd still", {7'b0, t_upd}, 8'h01);
    check("R8 sec held", reg_sec, 8'h00);
    freeze = 1'b0;
    do_tick();
    check("R8 counter ran", reg_sec, 8'h02);
  endtask

  task automatic t_alarm();
    bin_mode = 1'b0; mode_24h = 1'b1;
    alm_sec = 8'h05; alm_min = 8'hC0; alm_hour = 8'hC0;
    do_load(8'h10, 8'h30, 8'h04, 8'h00, 8'h01, 8'h01, 8'h01);
    do_tick();
    check("R9 wildcard match", {7'b0, t_alm}, 8'h01);
    do_tick();
    check("R9 no match", {7'b0, t_alm}, 8'h00);
    alm_sec = 8'hC0; alm_hour = 8'h07;
    do_tick();
    check("R9 hour mismatch", {7'b0, t_alm}, 8'h00);
    bin_mode = 1'b1;
    alm_sec = 8'd12; alm_min = 8'hC0; alm_hour = 8'hC0;
    do_load(8'd10, 8'd30, 8'd11, 8'd0, 8'd1, 8'd1, 8'd1);
    do_tick();
    check("R9 binary match", {7'b0, t_alm}, 8'h01);
    alm_sec = 8'h12;
    do_load(8'd10, 8'd30, 8'd11, 8'd0, 8'd1, 8'd1, 8'd1);
    do_tick();
    check("R9 encoding used", {7'b0, t_alm}, 8'h00);
    bin_mode = 1'b0; alm_sec = 8'h3F; alm_min = 8'h3F; alm_hour = 8'h3F;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_rollover();
    t_binary();
    t_12h();
    t_leap();
    t_osc_gate();
    t_window();
    t_freeze();
    t_alarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule